// File: doc/BRIEF.md
# Supply Level Detector Sequencer

This block is the digital side of an on-chip supply voltage level detector. Software selects one of eight thresholds in a level register and then writes a go bit in a control register. The block does not measure straight away. It waits for the next rising edge of a slow prescaler tap clock and enables the analog comparator only while that tap is high. On the falling edge of the tap that closes the window, it stores the comparator output as the result. A busy flag covers the whole interval, from the accepted go write to the end of the window.

The tap clock is asynchronous to the system clock. It passes through a synchroniser, and its edges are detected in the system clock domain. The threshold code is captured when the go write is accepted, so a later write to the level register cannot disturb a measurement in progress. While the device sleeps, the detector is inhibited: a pending or running measurement is dropped and go writes are refused.

The control register also holds two watchdog-disable bits. They can be read and written, and they are driven out to the watchdog logic.

Top module: `supply_level_seq`

## Requirements
- R1: After reset, both registers read 0, `det_en_o` is 0, and both watchdog-disable outputs are 0.
- R2: A write with `wr_sel_i`=1 stores bits 2..0 as the level code. Reading with `rd_sel_i`=1 returns that code in bits 2..0, and bit 3 reads 0.
- R3: In the control register (`wr_sel_i`=0), bits 1 and 0 are read/write. Bit 1 drives `osc_wd_dis_o` and bit 0 drives `logic_wd_dis_o`.
- R4: Writing 1 to control bit 2 while idle and awake sets busy, which reads back on control bit 2, from the next cycle on. `det_en_o` stays 0 until a rising edge of the tap arrives after that write. A tap that is already high does not count as an edge.
- R5: `det_en_o` is 1 only during the tap high phase that follows the accepted go write. During that phase, `det_level_o` equals the level code held at the go write, even if the level register is rewritten meanwhile.
- R6: On the tap falling edge that ends the window, control bit 3 is loaded from `det_cmp_i`: 1 means the supply is below the threshold, 0 means above. Busy and `det_en_o` then clear. Bit 3 is not checked while busy.
- R7: When `sleep_i` is high, any pending or running measurement is aborted on the next cycle, and busy and `det_en_o` clear. The stored result keeps its previous value.
- R8: A go write is ignored while `sleep_i` is high or while busy. It neither restarts the sequence nor recaptures the level code.
- R9: `det_en_o` is never 1 while busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tap_clk_i | input | 1 | Slow prescaler tap, asynchronous |
| sleep_i | input | 1 | Sleep mode; inhibits the detector |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_sel_i | input | 1 | Write target: 0 control, 1 level |
| wr_data_i | input | LVL_W+1 | Write data |
| rd_sel_i | input | 1 | Read target: 0 control, 1 level |
| rd_data_o | output | LVL_W+1 | Read data, combinational |
| det_en_o | output | 1 | Comparator enable |
| det_level_o | output | LVL_W | Threshold code to the comparator |
| det_cmp_i | input | 1 | Comparator output, 1 when the supply is below the threshold |
| osc_wd_dis_o | output | 1 | Oscillator watchdog disable |
| logic_wd_dis_o | output | 1 | Logic watchdog disable |

## Verification
The bench builds the block with its defaults: a 3-bit level code and a two-stage tap synchroniser. With that configuration, every level code can be swept against both comparator polarities, and the capture of the code and the result can be checked for each of the sixteen pairs. The tap is driven by the bench, so the bench can place a go write against either tap phase, start sleep during a window, and send go writes while busy.

// File: rtl/slv_pkg.sv
package slv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MEAS = 2'd2
    } slv_state_e;

    // control register bit positions (software-visible)
    localparam int CTRL_RES_BIT = 3;
    localparam int CTRL_GO_BIT  = 2;
    localparam int CTRL_OSC_BIT = 1;
    localparam int CTRL_LOG_BIT = 0;
endpackage

// File: rtl/slv_tap_sync.sv
module slv_tap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_i,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], tap_i};
        sync_d.prev  = sync_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o =  sync_q.chain[STAGES-1] & ~sync_q.prev;
    assign fall_o = ~sync_q.chain[STAGES-1] &  sync_q.prev;
endmodule

// File: rtl/slv_regs.sv
module slv_regs #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [LVL_W:0]   wr_data_i,
    output logic [LVL_W-1:0] level_o,
    output logic             osc_dis_o,
    output logic             log_dis_o,
    output logic             go_o
);
    import slv_pkg::*;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             osc_dis;
        logic             log_dis;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_bits;

    always_comb begin
        regs_d = regs_q;
        if (wr_en_i && wr_sel_i) begin
            regs_d.level = wr_data_i[LVL_W-1:0];
        end
        if (wr_en_i && !wr_sel_i) begin
            regs_d.osc_dis = wr_data_i[CTRL_OSC_BIT];
            regs_d.log_dis = wr_data_i[CTRL_LOG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign unused_bits = wr_data_i[LVL_W];
    assign level_o     = regs_q.level;
    assign osc_dis_o   = regs_q.osc_dis;
    assign log_dis_o   = regs_q.log_dis;
    assign go_o        = wr_en_i & ~wr_sel_i & wr_data_i[CTRL_GO_BIT];
endmodule

// File: rtl/slv_fsm.sv
module slv_fsm #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic             sleep_i,
    input  logic             tap_rise_i,
    input  logic             tap_fall_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic             cmp_i,
    output logic             busy_o,
    output logic             det_en_o,
    output logic [LVL_W-1:0] det_level_o,
    output logic             result_o
);
    import slv_pkg::*;

    typedef struct packed {
        slv_state_e       st;
        logic [LVL_W-1:0] lvl;
        logic             res;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (sleep_i) begin
            fsm_d.st = ST_IDLE;
        end else begin
            unique case (fsm_q.st)
                ST_IDLE: if (go_i) begin
                    fsm_d.st  = ST_WAIT;
                    fsm_d.lvl = level_i;
                end
                ST_WAIT: if (tap_rise_i) fsm_d.st = ST_MEAS;
                ST_MEAS: if (tap_fall_i) begin
                    fsm_d.st  = ST_IDLE;
                    fsm_d.res = cmp_i;
                end
                default: fsm_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_IDLE, lvl: '0, res: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign busy_o      = (fsm_q.st != ST_IDLE);
    assign det_en_o    = (fsm_q.st == ST_MEAS);
    assign det_level_o = fsm_q.lvl;
    assign result_o    = fsm_q.res;
endmodule

// File: rtl/supply_level_seq.sv
module supply_level_seq #(
    parameter int LVL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_clk_i,
    input  logic             sleep_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [LVL_W:0]   wr_data_i,
    input  logic             rd_sel_i,
    output logic [LVL_W:0]   rd_data_o,
    output logic             det_en_o,
    output logic [LVL_W-1:0] det_level_o,
    input  logic             det_cmp_i,
    output logic             osc_wd_dis_o,
    output logic             logic_wd_dis_o
);
    import slv_pkg::*;

    logic             tap_rise_w, tap_fall_w, go_w, busy_w, res_w;
    logic [LVL_W-1:0] level_w;

    slv_tap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .tap_i  (tap_clk_i),
        .rise_o (tap_rise_w),
        .fall_o (tap_fall_w)
    );

    slv_regs #(.LVL_W(LVL_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .level_o   (level_w),
        .osc_dis_o (osc_wd_dis_o),
        .log_dis_o (logic_wd_dis_o),
        .go_o      (go_w)
    );

    slv_fsm #(.LVL_W(LVL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go_w),
        .sleep_i     (sleep_i),
        .tap_rise_i  (tap_rise_w),
        .tap_fall_i  (tap_fall_w),
        .level_i     (level_w),
        .cmp_i       (det_cmp_i),
        .busy_o      (busy_w),
        .det_en_o    (det_en_o),
        .det_level_o (det_level_o),
        .result_o    (res_w)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_sel_i) begin
            rd_data_o[LVL_W-1:0] = level_w;
        end else begin
            rd_data_o[CTRL_RES_BIT] = res_w;
            rd_data_o[CTRL_GO_BIT]  = busy_w;
            rd_data_o[CTRL_OSC_BIT] = osc_wd_dis_o;
            rd_data_o[CTRL_LOG_BIT] = logic_wd_dis_o;
        end
    end
endmodule

// File: rtl/slv_chk.sv
module slv_chk #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [LVL_W:0]   wr_data_i,
    input logic             det_en_o,
    input logic [LVL_W-1:0] det_level_o,
    input logic             det_cmp_i,
    input logic             busy,
    input logic             result
);
    // R9
    en_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_en_o |-> busy);

    // R7
    sleep_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !busy);

    // R4
    busy_from_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en_i && !wr_sel_i && wr_data_i[2] && !sleep_i));

    // R5
    level_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_en_o && $past(det_en_o)) |-> $stable(det_level_o));

    // R6
    result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(det_en_o) && !$past(sleep_i)) |-> (result == $past(det_cmp_i)));
endmodule

bind supply_level_seq slv_chk #(.LVL_W(LVL_W)) i_slv_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_i     (sleep_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .det_en_o    (det_en_o),
    .det_level_o (det_level_o),
    .det_cmp_i   (det_cmp_i),
    .busy        (busy_w),
    .result      (res_w)
);

// File: tb/test_supply_level_seq.sv
module test_supply_level_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tap = 1'b0;
    logic       sleep = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [3:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [3:0] rd_data;
    logic       det_en;
    logic [2:0] det_level;
    logic       cmp = 1'b0;
    logic       osc_dis, log_dis;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    supply_level_seq i_supply_level_seq (
        .clk(clk), .rst_n(rst_n), .tap_clk_i(tap), .sleep_i(sleep),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .rd_sel_i(rd_sel), .rd_data_o(rd_data),
        .det_en_o(det_en), .det_level_o(det_level), .det_cmp_i(cmp),
        .osc_wd_dis_o(osc_dis), .logic_wd_dis_o(log_dis)
    );

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic sel, output logic [3:0] d);
        rd_sel = sel;
        #0.5;
        d = rd_data;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(1'b0, v); chk("R1 ctrl", v, 4'h0);
        rd(1'b1, v); chk("R1 level", v, 4'h0);
        chk("R1 det_en", {3'b0, det_en}, 4'h0);
        chk("R1 wd outs", {2'b0, osc_dis, log_dis}, 4'h0);

        // R3 watchdog-disable bits
        wr(1'b0, 4'b0011);
        rd(1'b0, v); chk("R3 ctrl rw 11", v, 4'b0011);
        chk("R3 outs 11", {2'b0, osc_dis, log_dis}, 4'b0011);
        wr(1'b0, 4'b1010);
        rd(1'b0, v); chk("R3 ctrl rw 10", v, 4'b0010);
        chk("R3 outs 10", {2'b0, osc_dis, log_dis}, 4'b0010);
        wr(1'b0, 4'b0000);

        // R2/R4/R5/R6/R9 sweep over every level and comparator polarity
        for (int lvl = 0; lvl < 8; lvl++) begin
            for (int c = 0; c < 2; c++) begin
                wr(1'b1, {1'b1, lvl[2:0]});
                rd(1'b1, v); chk("R2 level readback", v, {1'b0, lvl[2:0]});
                wr(1'b0, 4'b0100);
                rd(1'b0, v); chk("R4 busy after go", {3'b0, v[2]}, 4'h1);
                tick(4);
                chk("R4 no enable before edge", {3'b0, det_en}, 4'h0);
                tap = 1'b1;
                tick(4);
                chk("R5 enable in window", {3'b0, det_en}, 4'h1);
                rd(1'b0, v); chk("R9 busy in window", {3'b0, v[2]}, 4'h1);
                chk("R5 level out", {1'b0, det_level}, {1'b0, lvl[2:0]});
                wr(1'b1, {1'b0, ~lvl[2:0]});
                chk("R5 level held", {1'b0, det_level}, {1'b0, lvl[2:0]});
                cmp = c[0];
                tick(2);
                tap = 1'b0;
                tick(4);
                chk("R6 enable off", {3'b0, det_en}, 4'h0);
                rd(1'b0, v); chk("R6 result and idle", v, {c[0], 3'b000});
                cmp = 1'b0;
            end
        end

        // R7 sleep aborts; result keeps 1 from last sweep step
        wr(1'b0, 4'b0100);
        tap = 1'b1;
        tick(4);
        chk("R7 window open", {3'b0, det_en}, 4'h1);
        cmp = 1'b0;
        sleep = 1'b1;
        tick(2);
        chk("R7 enable off", {3'b0, det_en}, 4'h0);
        rd(1'b0, v); chk("R7 busy off, result kept", v, 4'b1000);
        tap = 1'b0;
        tick(4);
        rd(1'b0, v); chk("R7 result kept after fall", v, 4'b1000);

        // R8 go during sleep ignored
        wr(1'b0, 4'b0100);
        rd(1'b0, v); chk("R8 go in sleep", {3'b0, v[2]}, 4'h0);
        sleep = 1'b0;
        tick(2);
        tap = 1'b1; tick(4);
        chk("R8 no window after sleep go", {3'b0, det_en}, 4'h0);
        tap = 1'b0; tick(4);

        // R8 go while busy does not recapture level
        wr(1'b1, 4'd2);
        wr(1'b0, 4'b0100);
        wr(1'b1, 4'd5);
        wr(1'b0, 4'b0100);
        tap = 1'b1; tick(4);
        chk("R8 level from first go", {1'b0, det_level}, 4'd2);
        cmp = 1'b0;
        tap = 1'b0; tick(4);
        rd(1'b0, v); chk("R8 finished once", v, 4'b0000);

        // R4 go while tap already high waits for a fresh edge
        tap = 1'b1; tick(4);
        wr(1'b0, 4'b0100);
        tick(4);
        chk("R4 high tap no edge", {3'b0, det_en}, 4'h0);
        rd(1'b0, v); chk("R4 still busy", {3'b0, v[2]}, 4'h1);
        tap = 1'b0; tick(4);
        chk("R4 no enable on fall", {3'b0, det_en}, 4'h0);
        rd(1'b0, v); chk("R4 busy across low", {3'b0, v[2]}, 4'h1);
        cmp = 1'b1;
        tap = 1'b1; tick(4);
        chk("R5 window on next rise", {3'b0, det_en}, 4'h1);
        tap = 1'b0; tick(4);
        rd(1'b0, v); chk("R6 below result", v, 4'b1000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule